// File: doc/BRIEF.md
# Wide Bus Byte Pairing Unit

This unit turns a series of byte-granular outbound transfer commands into a stream of 16-bit words for a wide bus. Each command gives a byte count, a start address and a chain flag. The unit walks the addresses from the start address, takes one byte from a byte source per address, and packs the bytes in pairs. The first byte of a pair goes to the upper lane and the second byte goes to the lower lane.

A chained command can end on an odd byte. That byte is not sent. It is kept in a one-byte residual latch. The first byte of the next command is then placed in the upper lane, with the kept byte in the lower lane, so a word can span two commands. A run of N wide transfers is therefore issued as N-1 chained commands followed by one plain command. A plain command never leaves a byte behind. It sends an odd last byte as a half word, marked by a per-lane enable. If it carries no bytes, it flushes a pending residual on its own.

The output is a single registered word stage with a valid/ready handshake. The unit takes a new command only when the previous one has finished and the output stage is empty.

Top module: `byte_pair_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), out_valid is 0, cmd_ready is 1 and resid_pend is 0.
- R2: Within one command, two consecutive bytes form one word: the earlier byte on out_word[15:8], the later byte on out_word[7:0], and out_lanes = 2'b11 (bit 1 enables the upper lane, bit 0 the lower lane).
- R3: A plain (cmd_chain = 0) command with an odd count ends with a word holding the last byte on out_word[15:8], 8'h00 on out_word[7:0] and out_lanes = 2'b10.
- R4: A chained command with an odd count, and no residual consumed to make it even, does not send its last byte. resid_pend reads 1 once the command is done.
- R5: While a residual is pending, the first byte of the next command that has a nonzero count is sent with the residual as one word: the new byte on out_word[15:8], the residual on out_word[7:0], out_lanes = 2'b11. After that, resid_pend reads 0.
- R6: A plain command leaves resid_pend at 0. A plain command with count 0 and a pending residual emits one word with 8'h00 on out_word[15:8], the residual on out_word[7:0] and out_lanes = 2'b01.
- R7: A chained command with count 0 emits no word and leaves a pending residual in place.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_word and out_lanes hold their values. No byte is lost or repeated across stalls.
- R9: cmd_ready is 0 from the cycle after a command is accepted until that command has consumed all its bytes and the output stage is empty.
- R10: src_addr starts at the command's start address and steps by one for each accepted byte. Exactly cmd_count bytes are taken per command.
- R11: A synchronous reset discards a pending residual, so the next command's bytes pair among themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_count | input | CNT_W | Number of bytes in the command |
| cmd_addr | input | ADDR_W | Address of the first byte |
| cmd_chain | input | 1 | 1 = chained: keep an odd last byte for the next command |
| src_addr | output | ADDR_W | Address of the byte wanted next |
| src_valid | input | 1 | Byte source has the byte for src_addr |
| src_ready | output | 1 | Byte taken on this edge when valid |
| src_byte | input | 8 | Byte value for src_addr |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 16 | Packed word, upper lane in [15:8] |
| out_lanes | output | 2 | Lane enables, bit 1 upper, bit 0 lower |
| resid_pend | output | 1 | A residual byte is held |

## Verification
The bench builds the unit with CNT_W = 5 and ADDR_W = 10. With these values the largest possible command, 31 bytes, is odd and chained, and it runs within a few dozen cycles. The bench also takes this command through a residual, a zero-count chained command and a flush. Each byte's value is derived from its address, so every received word shows both the lane order and the address walk. A throttled out_ready pattern keeps the output stage full during chained hand-overs, which exercises the stall path and the marrying of bytes in the same run.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic [1:0]  lanes;
    logic [15:0] data;
  } word_t;

  localparam logic [1:0] LANES_BOTH = 2'b11;
  localparam logic [1:0] LANES_HI   = 2'b10;
  localparam logic [1:0] LANES_LO   = 2'b01;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HOLD,
    ACT_PAIR,
    ACT_MARRY,
    ACT_TAIL,
    ACT_STASH,
    ACT_FLUSH
  } act_e;

  // Build a word; disabled lanes are forced to zero.
  function automatic word_t make_word(input byte_t hi, input byte_t lo,
                                      input logic [1:0] lanes);
    word_t w;
    w.lanes      = lanes;
    w.data[15:8] = lanes[1] ? hi : 8'h00;
    w.data[7:0]  = lanes[0] ? lo : 8'h00;
    return w;
  endfunction

  // Decide what the assembler does with this cycle's byte or flush slot.
  function automatic act_e pick_action(input logic res_v, input logic hold_v,
                                       input logic last, input logic chain,
                                       input logic take, input logic flush);
    act_e a;
    a = ACT_NONE;
    if (flush)           a = ACT_FLUSH;
    else if (take) begin
      if (res_v)         a = ACT_MARRY;
      else if (hold_v)   a = ACT_PAIR;
      else if (!last)    a = ACT_HOLD;
      else if (chain)    a = ACT_STASH;
      else               a = ACT_TAIL;
    end
    return a;
  endfunction

  function automatic logic [31:0] addr_step(input logic [31:0] a);
    return a + 32'd1;
  endfunction

endpackage

// File: rtl/bpu_cmd_seq.sv
module bpu_cmd_seq #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_chain,
  input  logic              out_busy,
  input  logic              byte_take,
  input  logic              res_valid,
  output logic              cmd_ready,
  output logic              active,
  output logic              rem_zero,
  output logic              byte_last,
  output logic              chain_q,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;
  logic             active_q;
  logic             cmd_take;
  logic             done_evt;

  assign active    = active_q;
  assign cmd_ready = !active_q && !out_busy;
  assign cmd_take  = cmd_valid && cmd_ready;
  assign rem_zero  = (rem_q == '0);
  assign byte_last = (rem_q == ONE);
  // A plain command also waits for its residual flush before finishing.
  assign done_evt  = active_q && rem_zero && (chain_q || !res_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      addr_q   <= '0;
      chain_q  <= 1'b0;
    end else if (cmd_take) begin
      active_q <= 1'b1;
      rem_q    <= cmd_count;
      addr_q   <= cmd_addr;
      chain_q  <= cmd_chain;
    end else begin
      if (byte_take) begin
        rem_q  <= rem_q - ONE;
        addr_q <= ADDR_W'(bpu_pkg::addr_step(32'(addr_q)));
      end
      if (done_evt) active_q <= 1'b0;
    end
  end

  AST_BYTE_IN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> active_q && !rem_zero);                                   // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));                 // R10
  AST_CMD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> !cmd_ready);                                               // R9

endmodule

// File: rtl/bpu_pair_asm.sv
module bpu_pair_asm
  import bpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  byte_take,
  input  byte_t byte_in,
  input  logic  byte_last,
  input  logic  chain,
  input  logic  flush_take,
  output logic  push,
  output word_t word,
  output logic  res_valid,
  output byte_t res_byte
);

  byte_t hold_q;
  logic  hold_v;
  logic  res_v;
  act_e  act;
  logic  res_set;

  assign act       = pick_action(res_v, hold_v, byte_last, chain, byte_take, flush_take);
  assign res_valid = res_v;
  assign res_set   = (act == ACT_STASH);

  always_comb begin
    push = 1'b0;
    word = '0;
    case (act)
      ACT_MARRY: begin push = 1'b1; word = make_word(byte_in, res_byte, LANES_BOTH); end
      ACT_PAIR:  begin push = 1'b1; word = make_word(hold_q, byte_in, LANES_BOTH);   end
      ACT_TAIL:  begin push = 1'b1; word = make_word(byte_in, 8'h00, LANES_HI);      end
      ACT_FLUSH: begin push = 1'b1; word = make_word(8'h00, res_byte, LANES_LO);     end
      default:   begin push = 1'b0; word = '0;                                       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v   <= 1'b0;
      res_byte <= '0;
      res_v    <= 1'b0;
    end else begin
      case (act)
        ACT_HOLD:  begin hold_q <= byte_in; hold_v <= 1'b1; end
        ACT_PAIR:  hold_v <= 1'b0;
        ACT_STASH: begin res_byte <= byte_in; res_v <= 1'b1; end
        ACT_MARRY, ACT_FLUSH: res_v <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_RES_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    res_v && (byte_take || flush_take) |=> !res_v);                         // R5
  AST_STASH_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    res_set |-> chain && byte_last);                                        // R4
  AST_FLUSH_HAS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_take |-> res_v && !byte_take);                                    // R6

endmodule

// File: rtl/bpu_out_stage.sv
module bpu_out_stage
  import bpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  word_t       word_in,
  input  logic        out_ready,
  output logic        can_accept,
  output logic        out_valid,
  output logic [15:0] out_word,
  output logic [1:0]  out_lanes
);

  word_t w_q;
  logic  v_q;

  assign can_accept = !v_q || out_ready;
  assign out_valid  = v_q;
  assign out_word   = w_q.data;
  assign out_lanes  = w_q.lanes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      w_q <= '0;
    end else if (push) begin
      v_q <= 1'b1;
      w_q <= word_in;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> can_accept);                                                   // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_lanes)); // R8
  AST_LANES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lanes != 2'b00);                                      // R2

endmodule

// File: rtl/byte_pair_unit.sv
module byte_pair_unit
  import bpu_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_chain,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [7:0]        src_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_word,
  output logic [1:0]        out_lanes,
  output logic              resid_pend
);

  logic  active, rem_zero, byte_last, chain_q;
  logic  byte_take, flush_take, can_accept, push, res_valid;
  word_t word;
  byte_t res_byte;

  assign src_ready  = active && !rem_zero && can_accept;
  assign byte_take  = src_valid && src_ready;
  assign flush_take = active && rem_zero && !chain_q && res_valid && can_accept;
  assign resid_pend = res_valid;

  bpu_cmd_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_count(cmd_count), .cmd_addr(cmd_addr),
    .cmd_chain(cmd_chain), .out_busy(out_valid), .byte_take(byte_take),
    .res_valid(res_valid), .cmd_ready(cmd_ready), .active(active),
    .rem_zero(rem_zero), .byte_last(byte_last), .chain_q(chain_q),
    .addr_q(src_addr)
  );

  bpu_pair_asm u_asm (
    .clk(clk), .rst_n(rst_n),
    .byte_take(byte_take), .byte_in(src_byte), .byte_last(byte_last),
    .chain(chain_q), .flush_take(flush_take),
    .push(push), .word(word), .res_valid(res_valid), .res_byte(res_byte)
  );

  bpu_out_stage u_out (
    .clk(clk), .rst_n(rst_n),
    .push(push), .word_in(word), .out_ready(out_ready),
    .can_accept(can_accept), .out_valid(out_valid),
    .out_word(out_word), .out_lanes(out_lanes)
  );

  AST_PLAIN_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) && !chain_q |-> !resid_pend);                             // R6
  AST_CHAIN_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && rem_zero && chain_q && resid_pend |=> resid_pend && $stable(res_byte)); // R7

endmodule

// File: tb/sim_byte_pair_unit.sv
module sim_byte_pair_unit;
  localparam int CNT_W  = 5;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0, cmd_ready, cmd_chain = 1'b0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic [ADDR_W-1:0] cmd_addr = '0, src_addr;
  logic              src_valid = 1'b0, src_ready;
  logic [7:0]        src_byte;
  logic              out_valid, out_ready = 1'b1, resid_pend;
  logic [15:0]       out_word;
  logic [1:0]        out_lanes;

  byte_pair_unit #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_count(cmd_count), .cmd_addr(cmd_addr), .cmd_chain(cmd_chain),
    .src_addr(src_addr), .src_valid(src_valid), .src_ready(src_ready),
    .src_byte(src_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_lanes(out_lanes), .resid_pend(resid_pend)
  );

  function automatic logic [7:0] val(input int a);
    logic [31:0] x;
    x = a;
    return x[7:0] ^ 8'h5A;
  endfunction
  assign src_byte = val(int'(src_addr));

  int tests = 0, fails = 0;
  int n_taken = 0, n_expect = 0;
  logic [17:0] got[$], exp_q[$];
  logic        m_res_v = 1'b0;
  logic [7:0]  m_res = 8'h00;
  logic        stall_mode = 1'b0;
  int          rdy_cnt = 0;
  logic        prev_stall = 1'b0;
  logic [17:0] prev_w = '0;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    out_ready = stall_mode ? (rdy_cnt % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && {out_lanes, out_word} == prev_w, "R8", "stalled word held",
              int'({out_valid, out_lanes, out_word}), int'({1'b1, prev_w}));
      if (out_valid && out_ready) got.push_back({out_lanes, out_word});
      if (src_valid && src_ready) n_taken++;
      prev_stall = out_valid && !out_ready;
      prev_w     = {out_lanes, out_word};
    end else prev_stall = 1'b0;
  end

  // Expected words of one command, from the requirements.
  function automatic void model_move(input int cnt, input int addr, input logic chain);
    int i = 0;
    if (m_res_v && cnt > 0) begin
      exp_q.push_back({2'b11, val(addr), m_res});
      m_res_v = 1'b0;
      i = 1;
    end
    for (; i < cnt; i += 2) begin
      if (i + 1 < cnt) exp_q.push_back({2'b11, val(addr + i), val(addr + i + 1)});
      else if (chain) begin m_res = val(addr + i); m_res_v = 1'b1; end
      else exp_q.push_back({2'b10, val(addr + i), 8'h00});
    end
    if (cnt == 0 && !chain && m_res_v) begin
      exp_q.push_back({2'b01, 8'h00, m_res});
      m_res_v = 1'b0;
    end
  endfunction

  task automatic send(input int cnt, input int addr, input logic chain);
    model_move(cnt, addr, chain);
    n_expect += cnt;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_count = CNT_W'(cnt); cmd_addr = ADDR_W'(addr); cmd_chain = chain;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    check(!cmd_ready, "R9", "cmd_ready after accept", int'(cmd_ready), 0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!cmd_ready);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(got.size() == exp_q.size(), req, "word count", got.size(), exp_q.size());
    for (int k = 0; k < got.size() && k < exp_q.size(); k++)
      check(got[k] == exp_q[k], req, "word {lanes,data}", int'(got[k]), int'(exp_q[k]));
    check(n_taken == n_expect, "R10", "bytes taken", n_taken, n_expect);
    got.delete(); exp_q.delete();
    n_taken = 0; n_expect = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    m_res_v = 1'b0;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    check(resid_pend == 1'b0, "R1", "resid_pend", int'(resid_pend), 0);
  endtask

  task automatic t_even();
    send(4, 'h10, 1'b0); wait_idle(); compare("R2");
  endtask

  task automatic t_odd_plain();
    send(5, 'h20, 1'b0); wait_idle(); compare("R3");
    check(resid_pend == 1'b0, "R6", "resid after plain odd", int'(resid_pend), 0);
  endtask

  task automatic t_chain_pair();
    send(5, 'h03, 1'b1); wait_idle();
    check(resid_pend == 1'b1, "R4", "resid after chained odd", int'(resid_pend), 1);
    compare("R4");
    send(5, 'h09, 1'b0); wait_idle(); compare("R5");
    check(resid_pend == 1'b0, "R5", "resid after marry", int'(resid_pend), 0);
  endtask

  task automatic t_multi();
    send(3, 'h40, 1'b1); send(3, 'h50, 1'b1); send(1, 'h60, 1'b1); wait_idle();
    check(resid_pend == 1'b1, "R4", "resid after chain of 1", int'(resid_pend), 1);
    send(0, 'h00, 1'b0); wait_idle(); compare("R6");
    check(resid_pend == 1'b0, "R6", "resid after flush", int'(resid_pend), 0);
    send(31, 'h100, 1'b1); wait_idle(); compare("R4");
    send(0, 'h00, 1'b1); wait_idle(); compare("R7");
    check(resid_pend == 1'b1, "R7", "resid kept by chained zero", int'(resid_pend), 1);
    send(2, 'h200, 1'b0); wait_idle(); compare("R5");
  endtask

  task automatic t_stall();
    stall_mode = 1'b1;
    send(7, 'h80, 1'b1); send(6, 'h90, 1'b0); wait_idle();
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    compare("R8");
  endtask

  task automatic t_reset_res();
    send(3, 'h30, 1'b1); wait_idle(); compare("R4");
    do_reset();
    check(resid_pend == 1'b0, "R11", "resid after reset", int'(resid_pend), 0);
    send(2, 'h38, 1'b0); wait_idle(); compare("R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1; src_valid = 1'b1;
    @(negedge clk);
    t_reset();
    t_even();
    t_odd_plain();
    t_chain_pair();
    t_multi();
    t_stall();
    t_reset_res();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule